// File: doc/BRIEF.md
# Grouped-Pair Issue Scheduler with Two-Cycle Wakeup Loop

This block is a small out-of-order issue queue whose wakeup and select steps together take two clock cycles. Each queue slot holds either one instruction or a bound pair of dependent single-cycle instructions that share one destination tag. A pair is scheduled as a single two-cycle, non-pipelined operation. Once all of the slot's source tags are ready, the pair is granted. Its two instructions then leave a dual-slot payload on two consecutive cycles, and one tag broadcast wakes the consumers of the pair's result.

A front end writes at most one slot per cycle. Each write carries a destination tag, up to three source tags with per-source "used" and "already ready" flags, a pair flag, and two payload slots (identifier and operation bits). Completions from units outside the scheduler arrive on a result-tag input. On the output side there is one issued instruction per cycle, carrying its own identifier, and the scheduler's own tag broadcast. The broadcast is timed so that a dependent single instruction issues two cycles after its producer. A consumer of a pair issues two cycles after the pair's tail.

Top module: `mop_sched`

## Requirements
- R1: A single instruction granted in cycle n appears on the issue port in cycle n+1, and its destination tag is broadcast in cycle n+1. A consumer that waits only on it is granted no earlier than cycle n+2, so the two issue two cycles apart.
- R2: With WIRED_OR=1 a slot carries three source tags, and with WIRED_OR=0 it carries two. A slot is granted only when every source marked used is ready. A source marked unused never delays it.
- R3: A pair granted in cycle n issues its head in cycle n+1 and its tail in cycle n+2. Exactly one broadcast of the shared destination tag is made, in cycle n+2, and none in cycle n+1.
- R4: A single instruction that waits only on a pair's tag is granted in the cycle after the pair's tail issues, so it issues two cycles after the tail.
- R5: While a pair's tail is pending, no other slot is granted. The issue port therefore carries head, tail, and then the next instruction, with no interleaving.
- R6: At most one slot is granted per cycle. Among ready slots the one written earliest wins, whatever its slot index.
- R7: The queue holds DEPTH=8 slots. When all are occupied ins_ready is low, and a write offered then is dropped and never issues.
- R8: A granted slot is released at the end of its grant cycle, so ins_ready is high again in the following cycle.
- R9: A source whose tag is on the result input or on the scheduler's own broadcast in the cycle the slot is written counts as ready.
- R10: A result-input tag seen in cycle r makes the waiting slots eligible in cycle r+1.
- R11: Every issued instruction carries the identifier and operation bits written for it in its own payload slot.
- R12: After reset, iss_valid and bcast_valid are low and ins_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Write a slot this cycle |
| ins_ready | output | 1 | A free slot exists |
| ins_dst | input | TAG_W | Destination tag (shared by a pair) |
| ins_src_tag | input | NSRC x TAG_W | Source tags |
| ins_src_use | input | NSRC | Source is used |
| ins_src_rdy | input | NSRC | Source already available at write |
| ins_grp | input | 1 | Slot holds a pair |
| ins_head_id | input | ID_W | Head identifier |
| ins_head_op | input | OP_W | Head operation bits |
| ins_tail_id | input | ID_W | Tail identifier |
| ins_tail_op | input | OP_W | Tail operation bits |
| res_valid | input | 1 | External completion tag valid |
| res_tag | input | TAG_W | External completion tag |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_id | output | ID_W | Issued identifier |
| iss_op | output | OP_W | Issued operation bits |
| bcast_valid | output | 1 | Scheduler tag broadcast valid |
| bcast_tag | output | TAG_W | Broadcast destination tag |

## Verification
A lost or spurious ready bit shows at the issue port. Either a slot never issues, or it issues one or two cycles earlier than the exact cycle counted from its wakeup. A wrong age order shows as swapped identifiers on adjacent issue cycles. A sequencer that mishandles pairs shows up within two cycles of the grant in one of three ways: a tail that does not immediately follow its head, an interleaved foreign instruction, or a broadcast in the head cycle rather than the tail cycle. A leaked or stuck slot is seen through ins_ready when the queue is filled, and through a dropped write that issues anyway.

// File: rtl/mopq_pkg.sv
package mopq_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_TAIL = 1'b1
   } seq_state_t;
endpackage

// File: rtl/mopq_entry.sv
module mopq_entry #(
   parameter int TAG_W = 6,
   parameter int NSRC  = 3,
   parameter int ID_W  = 8,
   parameter int OP_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic                       free,
   input  logic [TAG_W-1:0]           in_dst,
   input  logic [NSRC-1:0][TAG_W-1:0] in_src,
   input  logic [NSRC-1:0]            in_use,
   input  logic [NSRC-1:0]            in_rdy,
   input  logic                       in_grp,
   input  logic [ID_W-1:0]            in_hid,
   input  logic [OP_W-1:0]            in_hop,
   input  logic [ID_W-1:0]            in_tid,
   input  logic [OP_W-1:0]            in_top,
   input  logic                       wk_a_v,
   input  logic [TAG_W-1:0]           wk_a_tag,
   input  logic                       wk_b_v,
   input  logic [TAG_W-1:0]           wk_b_tag,
   output logic                       valid,
   output logic                       ready,
   output logic [TAG_W-1:0]           dst,
   output logic                       grp,
   output logic [ID_W-1:0]            hid,
   output logic [OP_W-1:0]            hop,
   output logic [ID_W-1:0]            tid,
   output logic [OP_W-1:0]            top
);
   logic [NSRC-1:0][TAG_W-1:0] src_q;
   logic [NSRC-1:0]            rdy_q;
   logic [NSRC-1:0]            hit_st;
   logic [NSRC-1:0]            hit_in;

   for (genvar s = 0; s < NSRC; s++) begin : g_cmp
      assign hit_st[s] = (wk_a_v && (wk_a_tag == src_q[s])) ||
                         (wk_b_v && (wk_b_tag == src_q[s]));
      assign hit_in[s] = (wk_a_v && (wk_a_tag == in_src[s])) ||
                         (wk_b_v && (wk_b_tag == in_src[s]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         rdy_q <= '0;
         src_q <= '0;
         dst   <= '0;
         grp   <= 1'b0;
         hid   <= '0;
         hop   <= '0;
         tid   <= '0;
         top   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         src_q <= in_src;
         rdy_q <= ~in_use | in_rdy | hit_in;
         dst   <= in_dst;
         grp   <= in_grp;
         hid   <= in_hid;
         hop   <= in_hop;
         tid   <= in_tid;
         top   <= in_top;
      end else begin
         if (free) valid <= 1'b0;
         rdy_q <= rdy_q | hit_st;
      end
   end

   assign ready = valid && (&rdy_q);
endmodule

// File: rtl/mopq_pick.sv
module mopq_pick #(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] req,
   input  logic [DEPTH-1:0] ins_oh,
   output logic [DEPTH-1:0] gnt
);
   // older_q[i][j] set: slot i was written before slot j
   logic [DEPTH-1:0] older_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
               if (ins_oh[i])      older_q[i][j] <= 1'b0;
               else if (ins_oh[j]) older_q[i][j] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         logic blk;
         blk = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && req[j] && older_q[j][i]) blk = 1'b1;
         end
         gnt[i] = req[i] && !blk;
      end
   end
endmodule

// File: rtl/mopq_seq.sv
module mopq_seq
   import mopq_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int ID_W  = 8,
   parameter int OP_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gnt_v,
   input  logic [TAG_W-1:0] g_dst,
   input  logic             g_grp,
   input  logic [ID_W-1:0]  g_hid,
   input  logic [OP_W-1:0]  g_hop,
   input  logic [ID_W-1:0]  g_tid,
   input  logic [OP_W-1:0]  g_top,
   output logic             busy,
   output logic             iss_valid,
   output logic [ID_W-1:0]  iss_id,
   output logic [OP_W-1:0]  iss_op,
   output logic             bc_valid,
   output logic [TAG_W-1:0] bc_tag
);
   seq_state_t       st_q;
   logic [ID_W-1:0]  tid_q;
   logic [OP_W-1:0]  top_q;
   logic [TAG_W-1:0] dst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SEQ_IDLE;
         iss_valid <= 1'b0;
         iss_id    <= '0;
         iss_op    <= '0;
         bc_valid  <= 1'b0;
         bc_tag    <= '0;
         tid_q     <= '0;
         top_q     <= '0;
         dst_q     <= '0;
      end else if (st_q == SEQ_TAIL) begin
         iss_valid <= 1'b1;
         iss_id    <= tid_q;
         iss_op    <= top_q;
         bc_valid  <= 1'b1;
         bc_tag    <= dst_q;
         st_q      <= SEQ_IDLE;
      end else if (gnt_v) begin
         iss_valid <= 1'b1;
         iss_id    <= g_hid;
         iss_op    <= g_hop;
         if (g_grp) begin
            st_q     <= SEQ_TAIL;
            tid_q    <= g_tid;
            top_q    <= g_top;
            dst_q    <= g_dst;
            bc_valid <= 1'b0;
         end else begin
            bc_valid <= 1'b1;
            bc_tag   <= g_dst;
         end
      end else begin
         iss_valid <= 1'b0;
         bc_valid  <= 1'b0;
      end
   end

   assign busy = (st_q == SEQ_TAIL);
endmodule

// File: rtl/mop_sched.sv
module mop_sched #(
   parameter int  DEPTH    = 8,
   parameter int  TAG_W    = 6,
   parameter int  ID_W     = 8,
   parameter int  OP_W     = 8,
   parameter bit  WIRED_OR = 1'b1,
   localparam int NSRC     = WIRED_OR ? 3 : 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ins_valid,
   output logic                       ins_ready,
   input  logic [TAG_W-1:0]           ins_dst,
   input  logic [NSRC-1:0][TAG_W-1:0] ins_src_tag,
   input  logic [NSRC-1:0]            ins_src_use,
   input  logic [NSRC-1:0]            ins_src_rdy,
   input  logic                       ins_grp,
   input  logic [ID_W-1:0]            ins_head_id,
   input  logic [OP_W-1:0]            ins_head_op,
   input  logic [ID_W-1:0]            ins_tail_id,
   input  logic [OP_W-1:0]            ins_tail_op,
   input  logic                       res_valid,
   input  logic [TAG_W-1:0]           res_tag,
   output logic                       iss_valid,
   output logic [ID_W-1:0]            iss_id,
   output logic [OP_W-1:0]            iss_op,
   output logic                       bcast_valid,
   output logic [TAG_W-1:0]           bcast_tag
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("mop_sched: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || ID_W < 1 || OP_W < 1) begin : g_bad_width
      $error("mop_sched: widths must be positive");
   end

   logic [DEPTH-1:0] ent_valid;
   logic [DEPTH-1:0] ent_ready;
   logic [DEPTH-1:0] ins_oh;
   logic [DEPTH-1:0] load;
   logic [DEPTH-1:0] gnt;
   logic [DEPTH-1:0] req;
   logic             seq_busy;

   logic [TAG_W-1:0] e_dst [DEPTH];
   logic             e_grp [DEPTH];
   logic [ID_W-1:0]  e_hid [DEPTH];
   logic [OP_W-1:0]  e_hop [DEPTH];
   logic [ID_W-1:0]  e_tid [DEPTH];
   logic [OP_W-1:0]  e_top [DEPTH];

   logic [TAG_W-1:0] g_dst;
   logic             g_grp;
   logic [ID_W-1:0]  g_hid;
   logic [OP_W-1:0]  g_hop;
   logic [ID_W-1:0]  g_tid;
   logic [OP_W-1:0]  g_top;

   // lowest free slot takes the write
   always_comb begin
      logic found;
      found  = 1'b0;
      ins_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!ent_valid[i] && !found) begin
            ins_oh[i] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   assign ins_ready = ~&ent_valid;
   assign load      = (ins_valid && ins_ready) ? ins_oh : '0;
   assign req       = seq_busy ? '0 : ent_ready;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      mopq_entry #(.TAG_W(TAG_W), .NSRC(NSRC), .ID_W(ID_W), .OP_W(OP_W)) ent_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load[e]),
         .free    (gnt[e]),
         .in_dst  (ins_dst),
         .in_src  (ins_src_tag),
         .in_use  (ins_src_use),
         .in_rdy  (ins_src_rdy),
         .in_grp  (ins_grp),
         .in_hid  (ins_head_id),
         .in_hop  (ins_head_op),
         .in_tid  (ins_tail_id),
         .in_top  (ins_tail_op),
         .wk_a_v  (bcast_valid),
         .wk_a_tag(bcast_tag),
         .wk_b_v  (res_valid),
         .wk_b_tag(res_tag),
         .valid   (ent_valid[e]),
         .ready   (ent_ready[e]),
         .dst     (e_dst[e]),
         .grp     (e_grp[e]),
         .hid     (e_hid[e]),
         .hop     (e_hop[e]),
         .tid     (e_tid[e]),
         .top     (e_top[e])
      );
   end

   mopq_pick #(.DEPTH(DEPTH)) pick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .ins_oh(load),
      .gnt   (gnt)
   );

   always_comb begin
      g_dst = '0;
      g_grp = 1'b0;
      g_hid = '0;
      g_hop = '0;
      g_tid = '0;
      g_top = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (gnt[i]) begin
            g_dst = g_dst | e_dst[i];
            g_grp = g_grp | e_grp[i];
            g_hid = g_hid | e_hid[i];
            g_hop = g_hop | e_hop[i];
            g_tid = g_tid | e_tid[i];
            g_top = g_top | e_top[i];
         end
      end
   end

   mopq_seq #(.TAG_W(TAG_W), .ID_W(ID_W), .OP_W(OP_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_v    (|gnt),
      .g_dst    (g_dst),
      .g_grp    (g_grp),
      .g_hid    (g_hid),
      .g_hop    (g_hop),
      .g_tid    (g_tid),
      .g_top    (g_top),
      .busy     (seq_busy),
      .iss_valid(iss_valid),
      .iss_id   (iss_id),
      .iss_op   (iss_op),
      .bc_valid (bcast_valid),
      .bc_tag   (bcast_tag)
   );
endmodule

// File: rtl/mopq_sched_chk.sv
module mopq_sched_chk #(
   parameter int DEPTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_ready,
   input logic [DEPTH-1:0] ent_valid,
   input logic [DEPTH-1:0] gnt,
   input logic             busy,
   input logic             iss_valid,
   input logic             bcast_valid
);
   // R6
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R5
   tail_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (gnt == '0));

   // R3
   tail_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (iss_valid && bcast_valid && !busy));

   // R3
   head_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iss_valid && !bcast_valid));

   // R1
   bcast_with_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |-> iss_valid);

   // R7
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&ent_valid) |-> !ins_ready);

   // R8
   grant_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt) |=> ((ent_valid & $past(gnt)) == '0));
endmodule

bind mop_sched mopq_sched_chk #(.DEPTH(DEPTH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ins_ready  (ins_ready),
   .ent_valid  (ent_valid),
   .gnt        (gnt),
   .busy       (seq_busy),
   .iss_valid  (iss_valid),
   .bcast_valid(bcast_valid)
);

// File: tb/mop_sched_tb.sv
module mop_sched_tb_top;
   localparam int TAG_W = 6;
   localparam int ID_W  = 8;
   localparam int OP_W  = 8;
   localparam int NSRC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic                       ins_valid = 1'b0;
   logic                       ins_ready;
   logic [TAG_W-1:0]           ins_dst = '0;
   logic [NSRC-1:0][TAG_W-1:0] ins_src_tag = '0;
   logic [NSRC-1:0]            ins_src_use = '0;
   logic [NSRC-1:0]            ins_src_rdy = '0;
   logic                       ins_grp = 1'b0;
   logic [ID_W-1:0]            ins_head_id = '0;
   logic [OP_W-1:0]            ins_head_op = '0;
   logic [ID_W-1:0]            ins_tail_id = '0;
   logic [OP_W-1:0]            ins_tail_op = '0;
   logic                       res_valid = 1'b0;
   logic [TAG_W-1:0]           res_tag = '0;
   logic                       iss_valid;
   logic [ID_W-1:0]            iss_id;
   logic [OP_W-1:0]            iss_op;
   logic                       bcast_valid;
   logic [TAG_W-1:0]           bcast_tag;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   mop_sched #(.DEPTH(8), .TAG_W(TAG_W), .ID_W(ID_W), .OP_W(OP_W), .WIRED_OR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_dst(ins_dst),
      .ins_src_tag(ins_src_tag), .ins_src_use(ins_src_use), .ins_src_rdy(ins_src_rdy),
      .ins_grp(ins_grp), .ins_head_id(ins_head_id), .ins_head_op(ins_head_op),
      .ins_tail_id(ins_tail_id), .ins_tail_op(ins_tail_op),
      .res_valid(res_valid), .res_tag(res_tag),
      .iss_valid(iss_valid), .iss_id(iss_id), .iss_op(iss_op),
      .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic exp_iss(input string req, input logic v, input logic [ID_W-1:0] id);
      check({req, " iss_valid"}, int'(iss_valid), int'(v));
      if (v) check({req, " iss_id"}, int'(iss_id), int'(id));
   endtask

   task automatic exp_bc(input string req, input logic v, input logic [TAG_W-1:0] tag);
      check({req, " bcast_valid"}, int'(bcast_valid), int'(v));
      if (v) check({req, " bcast_tag"}, int'(bcast_tag), int'(tag));
   endtask

   task automatic put(input logic [ID_W-1:0] hid, input logic grp, input logic [ID_W-1:0] tid,
                      input logic [TAG_W-1:0] dst, input logic [TAG_W-1:0] s0,
                      input logic [TAG_W-1:0] s1, input logic [TAG_W-1:0] s2,
                      input logic [2:0] use_m, input logic [2:0] rdy_m);
      ins_valid   = 1'b1;
      ins_head_id = hid;
      ins_head_op = ~hid;
      ins_tail_id = tid;
      ins_tail_op = ~tid;
      ins_grp     = grp;
      ins_dst     = dst;
      ins_src_tag = {s2, s1, s0};
      ins_src_use = use_m;
      ins_src_rdy = rdy_m;
   endtask

   task automatic idle();
      ins_valid = 1'b0;
      ins_grp   = 1'b0;
      res_valid = 1'b0;
   endtask

   task automatic wake(input logic [TAG_W-1:0] t);
      res_valid = 1'b1;
      res_tag   = t;
   endtask

   // R12
   task automatic t_reset();
      check("R12 iss_valid", int'(iss_valid), 0);
      check("R12 bcast_valid", int'(bcast_valid), 0);
      check("R12 ins_ready", int'(ins_ready), 1);
   endtask

   // R1, R11: producer then dependent consumer
   task automatic t_single_chain();
      put(8'h11, 1'b0, 8'h00, 6'd1, 6'd0, 6'd0, 6'd0, 3'b000, 3'b000);
      tick();
      put(8'h12, 1'b0, 8'h00, 6'd2, 6'd1, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      exp_iss("R1 producer issue", 1'b1, 8'h11);
      check("R11 producer op", int'(iss_op), int'(~8'h11 & 8'hFF));
      exp_bc("R1 producer bcast", 1'b1, 6'd1);
      tick();
      exp_iss("R1 no issue in loop gap", 1'b0, 8'h00);
      tick();
      exp_iss("R1 consumer issue", 1'b1, 8'h12);
      exp_bc("R1 consumer bcast", 1'b1, 6'd2);
      tick();
      exp_iss("R1 quiet after", 1'b0, 8'h00);
      tick();
   endtask

   // R3, R4, R11: pair then consumer of pair
   task automatic t_pair_chain();
      put(8'h21, 1'b1, 8'h22, 6'd3, 6'd0, 6'd0, 6'd0, 3'b000, 3'b000);
      tick();
      put(8'h23, 1'b0, 8'h00, 6'd4, 6'd3, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      exp_iss("R3 head issue", 1'b1, 8'h21);
      exp_bc("R3 no bcast on head", 1'b0, 6'd0);
      tick();
      exp_iss("R3 tail issue", 1'b1, 8'h22);
      check("R11 tail op", int'(iss_op), int'(~8'h22 & 8'hFF));
      exp_bc("R3 single shared bcast", 1'b1, 6'd3);
      tick();
      exp_iss("R4 gap after tail", 1'b0, 8'h00);
      exp_bc("R3 no second bcast", 1'b0, 6'd0);
      tick();
      exp_iss("R4 consumer of pair", 1'b1, 8'h23);
      tick();
      tick();
   endtask

   // R5, R10: pair older than a single, both woken together
   task automatic t_pair_blocks();
      put(8'h31, 1'b1, 8'h32, 6'd5, 6'd40, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      put(8'h33, 1'b0, 8'h00, 6'd6, 6'd40, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      tick();
      exp_iss("R10 waiting, no issue", 1'b0, 8'h00);
      wake(6'd40);
      tick();
      idle();
      exp_iss("R10 grant cycle, no issue yet", 1'b0, 8'h00);
      tick();
      exp_iss("R5 head first", 1'b1, 8'h31);
      tick();
      exp_iss("R5 tail not interleaved", 1'b1, 8'h32);
      exp_bc("R5 pair bcast", 1'b1, 6'd5);
      tick();
      exp_iss("R5 single after tail", 1'b1, 8'h33);
      exp_bc("R5 single bcast", 1'b1, 6'd6);
      tick();
      tick();
   endtask

   // R6: age order differs from slot order
   task automatic t_oldest_first();
      put(8'h41, 1'b0, 8'h00, 6'd7, 6'd41, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      put(8'h42, 1'b0, 8'h00, 6'd8, 6'd42, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      wake(6'd41);
      tick();
      idle();
      tick();
      exp_iss("R6 first waiter", 1'b1, 8'h41);
      put(8'h43, 1'b0, 8'h00, 6'd9, 6'd42, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      wake(6'd42);
      tick();
      idle();
      tick();
      exp_iss("R6 older slot wins", 1'b1, 8'h42);
      tick();
      exp_iss("R6 younger next cycle", 1'b1, 8'h43);
      tick();
      tick();
   endtask

   // R2: three used sources, one unused source ignored
   task automatic t_all_sources();
      put(8'h51, 1'b0, 8'h00, 6'd10, 6'd43, 6'd44, 6'd45, 3'b111, 3'b000);
      tick();
      put(8'h52, 1'b0, 8'h00, 6'd12, 6'd46, 6'd63, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      wake(6'd43);
      tick();
      wake(6'd44);
      tick();
      idle();
      tick();
      exp_iss("R2 two of three ready", 1'b0, 8'h00);
      tick();
      exp_iss("R2 still waiting", 1'b0, 8'h00);
      wake(6'd46);
      tick();
      idle();
      tick();
      exp_iss("R2 unused source ignored", 1'b1, 8'h52);
      wake(6'd45);
      tick();
      idle();
      exp_iss("R2 third source just seen", 1'b0, 8'h00);
      tick();
      exp_iss("R2 all sources ready", 1'b1, 8'h51);
      tick();
      tick();
   endtask

   // R9: readiness captured in the write cycle
   task automatic t_insert_capture();
      put(8'h61, 1'b0, 8'h00, 6'd13, 6'd48, 6'd0, 6'd0, 3'b001, 3'b000);
      wake(6'd48);
      tick();
      idle();
      tick();
      exp_iss("R9 result tag at write", 1'b1, 8'h61);
      tick();
      put(8'h62, 1'b0, 8'h00, 6'd11, 6'd0, 6'd0, 6'd0, 3'b000, 3'b000);
      tick();
      idle();
      tick();
      exp_bc("R9 producer bcast", 1'b1, 6'd11);
      put(8'h63, 1'b0, 8'h00, 6'd14, 6'd11, 6'd0, 6'd0, 3'b001, 3'b000);
      tick();
      idle();
      tick();
      exp_iss("R9 own bcast at write", 1'b1, 8'h63);
      tick();
      tick();
   endtask

   // R7, R8: fill, refuse, drain
   task automatic t_full();
      for (int k = 0; k < 8; k++) begin
         put(8'h70 + 8'(k), 1'b0, 8'h00, 6'd20 + 6'(k), 6'd50, 6'd0, 6'd0, 3'b001, 3'b000);
         tick();
      end
      idle();
      check("R7 full refuses", int'(ins_ready), 0);
      put(8'h78, 1'b0, 8'h00, 6'd30, 6'd0, 6'd0, 6'd0, 3'b000, 3'b000);
      tick();
      tick();
      idle();
      tick();
      exp_iss("R7 dropped write not issued", 1'b0, 8'h00);
      wake(6'd50);
      tick();
      idle();
      check("R8 still full in grant cycle", int'(ins_ready), 0);
      tick();
      check("R8 freed after grant", int'(ins_ready), 1);
      for (int k = 0; k < 8; k++) begin
         exp_iss("R6 drain order", 1'b1, 8'h70 + 8'(k));
         tick();
      end
      exp_iss("R7 nothing after drain", 1'b0, 8'h00);
      tick();
      exp_iss("R7 dropped write never issues", 1'b0, 8'h00);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_chain();
      t_pair_chain();
      t_pair_blocks();
      t_oldest_first();
      t_all_sources();
      t_insert_capture();
      t_full();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule